// File: doc/BRIEF.md
# Grouped Carry-Skip Adder with Operand Latches

This block holds two adder operands in set-only latch registers and presents their sum, plus a carry-in, as a combinational result for the write bus. The 16-bit addition is split into four identical 4-bit slices. Inside a slice the carry ripples through full adders. Beside that ripple, each slice has a skip path that raises the slice carry-out as soon as its carry-in arrives, provided every bit position of the slice has at least one operand bit set.

The operand registers load from two sources. The first operand can be filled from the shared bus or from the accumulator, and the second operand only from the bus. A load strobe only sets bits: it ORs the source into the current contents. A clear strobe zeroes both operands. When a clear and a load fall in the same cycle, the clear is applied first, so the register takes the loaded value. When several sources are gated in the same cycle, they merge by OR.

The adder has no complement logic. Subtraction is done by loading a complemented operand and setting the carry-in. The carry out of the top slice is available as a separate output.

Top module: `skipadd_unit`

## Requirements
- R1: While reset is low, both operand registers are zero. After reset, with carry-in 0, `sum_o` is 0 and `cout_o` is 0.
- R2: `sum_o` equals operand X plus operand Y plus `cin_i`, modulo 2^16. It updates in the same cycle as the operands and `cin_i` change.
- R3: `cout_o` is bit 16 of the unsigned 17-bit sum X + Y + `cin_i`.
- R4: A cycle with `clr_i` high and no load strobe leaves X and Y at zero after the next clock edge.
- R5: `ld_x_acc_i` ORs `acc_i` into X. With `ld_x_bus_i` in the same cycle, X takes the OR of both sources and its previous bits.
- R6: `ld_x_bus_i` ORs `bus_i` into X, and `ld_y_bus_i` ORs `bus_i` into Y. Without a clear, bits that are already set stay set.
- R7: When `clr_i` and a load strobe are high in the same cycle, the register ends up holding exactly the loaded source value or values.
- R8: With no strobe for a register, that register holds its value whatever `bus_i` and `acc_i` do.
- R9: A slice's carry-out is 1 whenever its carry-in is 1 and every one of its 4 positions has X or Y set. The skip path and the ripple path never disagree.
- R10: Loading X = a and Y = ~b with `cin_i` = 1 gives `sum_o` = a - b modulo 2^16, and `cout_o` = 1 exactly when a >= b (unsigned).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 16 | Shared bus value, source for X and Y loads |
| acc_i | input | 16 | Accumulator value, source for the X copy strobe |
| clr_i | input | 1 | Clears X and Y at the clock edge |
| ld_x_acc_i | input | 1 | OR accumulator into X |
| ld_x_bus_i | input | 1 | OR bus into X |
| ld_y_bus_i | input | 1 | OR bus into Y |
| cin_i | input | 1 | Carry into the lowest slice |
| sum_o | output | 16 | Sum X + Y + cin, for the write bus |
| cout_o | output | 1 | Carry out of the top slice |

## Verification
Two functions can fall in the same cycle: a clear together with a load, and the accumulator copy together with a bus load into X. Both cases are driven on purpose. The bench starts every operand pair with a clear plus load cycle, and it drives one cycle in which both X sources are gated together. The result is judged through the sum with the other operand held at zero, against the OR of the sources that the bench computes itself. The skip and ripple paths are exercised at the same time by operands whose positions are all covered with carry-in 1, and their agreement is checked in every slice.

// File: rtl/skipadd_pkg.sv
package skipadd_pkg;
    // Strobe bundle for one operand latch.
    typedef struct packed {
        logic clr;
        logic ld_alt;
        logic ld_bus;
    } opnd_ctl_t;
endpackage

// File: rtl/full_adder_bit.sv
module full_adder_bit (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (ci & (a ^ b));
    end
endmodule

// File: rtl/operand_latch.sv
module operand_latch
    import skipadd_pkg::*;
#(
    parameter int W       = 16,
    parameter bit HAS_ALT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  opnd_ctl_t    ctl,
    input  logic [W-1:0] bus_val,
    input  logic [W-1:0] alt_val,
    output logic [W-1:0] q
);
    logic [W-1:0] alt_term;
    logic [W-1:0] base;

    generate
        if (HAS_ALT) begin : g_alt
            assign alt_term = ctl.ld_alt ? alt_val : '0;
        end else begin : g_noalt
            assign alt_term = '0;
        end
    endgenerate

    // The clear acts before the set, so a clear plus load gives the loaded value.
    always_comb begin
        base = ctl.clr ? '0 : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= base | alt_term | (ctl.ld_bus ? bus_val : '0);
        end
    end
endmodule

// File: rtl/carry_skip_group.sv
module carry_skip_group #(
    parameter int G = 4
) (
    input  logic [G-1:0] a,
    input  logic [G-1:0] b,
    input  logic         ci,
    output logic [G-1:0] s,
    output logic         ripple_co,
    output logic         skip_co,
    output logic         co
);
    logic [G:0] c;

    assign c[0] = ci;

    generate
        for (genvar i = 0; i < G; i++) begin : g_bit
            full_adder_bit fa_i (
                .a  (a[i]),
                .b  (b[i]),
                .ci (c[i]),
                .s  (s[i]),
                .co (c[i+1])
            );
        end
    endgenerate

    always_comb begin
        ripple_co = c[G];
        skip_co   = ci & (&(a | b));
        co        = ripple_co | skip_co;
    end
endmodule

// File: rtl/skipadd_unit.sv
module skipadd_unit
    import skipadd_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic             clr_i,
    input  logic             ld_x_acc_i,
    input  logic             ld_x_bus_i,
    input  logic             ld_y_bus_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int NGROUPS = WIDTH / GROUP;

    opnd_ctl_t        x_ctl;
    opnd_ctl_t        y_ctl;
    logic [WIDTH-1:0] x_q;
    logic [WIDTH-1:0] y_q;
    logic [NGROUPS:0] gc;
    logic [NGROUPS-1:0] grp_ripple;
    logic [NGROUPS-1:0] grp_skip;

    always_comb begin
        x_ctl = '{clr: clr_i, ld_alt: ld_x_acc_i, ld_bus: ld_x_bus_i};
        y_ctl = '{clr: clr_i, ld_alt: 1'b0, ld_bus: ld_y_bus_i};
    end

    operand_latch #(.W(WIDTH), .HAS_ALT(1'b1)) x_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (x_ctl),
        .bus_val (bus_i),
        .alt_val (acc_i),
        .q       (x_q)
    );

    operand_latch #(.W(WIDTH), .HAS_ALT(1'b0)) y_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (y_ctl),
        .bus_val (bus_i),
        .alt_val ('0),
        .q       (y_q)
    );

    assign gc[0] = cin_i;

    generate
        for (genvar g = 0; g < NGROUPS; g++) begin : g_slice
            carry_skip_group #(.G(GROUP)) grp_i (
                .a         (x_q[g*GROUP +: GROUP]),
                .b         (y_q[g*GROUP +: GROUP]),
                .ci        (gc[g]),
                .s         (sum_o[g*GROUP +: GROUP]),
                .ripple_co (grp_ripple[g]),
                .skip_co   (grp_skip[g]),
                .co        (gc[g+1])
            );
        end
    endgenerate

    assign cout_o = gc[NGROUPS];
endmodule

// File: rtl/skipadd_unit_chk.sv
module skipadd_unit_chk #(
    parameter int W  = 16,
    parameter int NG = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  bus_i,
    input logic [W-1:0]  acc_i,
    input logic          clr_i,
    input logic          ld_x_acc_i,
    input logic          ld_x_bus_i,
    input logic          ld_y_bus_i,
    input logic          cin_i,
    input logic [W-1:0]  sum_o,
    input logic          cout_o,
    input logic [W-1:0]  x_q,
    input logic [W-1:0]  y_q,
    input logic [NG-1:0] grp_ripple,
    input logic [NG-1:0] grp_skip
);
    logic [W:0] ref_sum;
    assign ref_sum = {1'b0, x_q} + {1'b0, y_q} + {{W{1'b0}}, cin_i};

    // R2 and R3
    assert_sum_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {cout_o, sum_o} == ref_sum);

    // R4
    assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !ld_x_acc_i && !ld_x_bus_i && !ld_y_bus_i) |=> (x_q == '0 && y_q == '0));

    // R6
    assert_y_or_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ld_y_bus_i) |=> (y_q == ($past(y_q) | $past(bus_i))));

    // R8
    assert_x_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_x_acc_i && !ld_x_bus_i) |=> $stable(x_q));

    // R9: the skip path never claims a carry that the ripple path lacks
    generate
        for (genvar g = 0; g < NG; g++) begin : g_grp
            assert_skip_agrees_R9: assert property (@(posedge clk) disable iff (!rst_n)
                grp_skip[g] |-> grp_ripple[g]);
        end
    endgenerate
endmodule

bind skipadd_unit skipadd_unit_chk #(.W(WIDTH), .NG(NGROUPS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_i      (bus_i),
    .acc_i      (acc_i),
    .clr_i      (clr_i),
    .ld_x_acc_i (ld_x_acc_i),
    .ld_x_bus_i (ld_x_bus_i),
    .ld_y_bus_i (ld_y_bus_i),
    .cin_i      (cin_i),
    .sum_o      (sum_o),
    .cout_o     (cout_o),
    .x_q        (x_q),
    .y_q        (y_q),
    .grp_ripple (grp_ripple),
    .grp_skip   (grp_skip)
);

// File: tb/skipadd_unit_tb_top.sv
module skipadd_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_i = '0;
    logic [15:0] acc_i = '0;
    logic        clr_i = 1'b0;
    logic        ld_x_acc_i = 1'b0;
    logic        ld_x_bus_i = 1'b0;
    logic        ld_y_bus_i = 1'b0;
    logic        cin_i = 1'b0;
    logic [15:0] sum_o;
    logic        cout_o;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    skipadd_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_i      (bus_i),
        .acc_i      (acc_i),
        .clr_i      (clr_i),
        .ld_x_acc_i (ld_x_acc_i),
        .ld_x_bus_i (ld_x_bus_i),
        .ld_y_bus_i (ld_y_bus_i),
        .cin_i      (cin_i),
        .sum_o      (sum_o),
        .cout_o     (cout_o)
    );

    task automatic chk(input string tag, input logic [16:0] exp);
        n_checks++;
        if ({cout_o, sum_o} !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, {cout_o, sum_o}, exp);
        end
    endtask

    function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                            input logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    // One strobe cycle: drive at negedge, edge happens, strobes drop at next negedge.
    task automatic strobe(input logic clr, input logic lxa, input logic lxb, input logic lyb,
                          input logic [15:0] acc, input logic [15:0] bus);
        @(negedge clk);
        clr_i = clr; ld_x_acc_i = lxa; ld_x_bus_i = lxb; ld_y_bus_i = lyb;
        acc_i = acc; bus_i = bus;
        @(negedge clk);
        clr_i = 0; ld_x_acc_i = 0; ld_x_bus_i = 0; ld_y_bus_i = 0;
    endtask

    // Clear plus load in one cycle: X from accumulator, Y from bus (R7).
    task automatic load_pair(input logic [15:0] a, input logic [15:0] b, input logic c);
        cin_i = c;
        strobe(1, 1, 0, 1, a, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, b, u;
        logic c;
        repeat (3) @(negedge clk);
        chk("R1 reset state", 17'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 17'h0);

        // R6: bus into X with Y clear, then Y, then OR-set into X
        strobe(0, 0, 1, 0, 16'hFFFF, 16'h1234);
        chk("R6 x from bus", ref_add(16'h1234, 0, 0));
        strobe(0, 0, 0, 1, 16'h0, 16'h0101);
        chk("R6 y from bus", ref_add(16'h1234, 16'h0101, 0));
        strobe(0, 0, 1, 0, 16'h0, 16'h00F0);
        chk("R6 x or-set", ref_add(16'h12F4, 16'h0101, 0));

        // R8: strobe-free cycles with changing bus and accumulator
        strobe(0, 0, 0, 0, 16'hFFFF, 16'hFFFF);
        chk("R8 hold", ref_add(16'h12F4, 16'h0101, 0));

        // R4: clear alone
        strobe(1, 0, 0, 0, 16'hFFFF, 16'hFFFF);
        chk("R4 clear", 17'h0);
        cin_i = 1;
        #1 chk("R2 cin only", 17'h1);
        cin_i = 0;

        // R5: accumulator alone, then both sources together after a clear
        strobe(0, 1, 0, 0, 16'h0F00, 16'h0);
        chk("R5 acc into x", ref_add(16'h0F00, 0, 0));
        strobe(1, 1, 1, 0, 16'hA000, 16'h000C);
        chk("R5 acc and bus merge", ref_add(16'hA00C, 0, 0));
        // R7: clear plus load gives exactly the loaded value
        strobe(1, 0, 1, 1, 16'h0, 16'h0003);
        chk("R7 clear plus load", ref_add(16'h0003, 16'h0003, 0));

        // R3 and R9: all-ones plus one, over every width
        for (int k = 1; k <= 16; k++) begin
            a = 16'((17'd1 << k) - 17'd1);
            load_pair(a, 16'h0001, 0);
            chk("R3 ones plus one", ref_add(a, 16'h0001, 0));
            load_pair(a, 16'h0000, 1);
            chk("R9 ones plus carry", ref_add(a, 16'h0000, 1));
        end
        load_pair(16'hAAAA, 16'h5555, 1);
        chk("R9 disjoint cover", 17'h10000);

        // R9: full cover per slice with mixed positions
        for (int i = 0; i < 200; i++) begin
            a = 16'($urandom);
            u = 16'($urandom);
            b = ~a | (a & u);
            load_pair(a, b, 1);
            chk("R9 covered positions", ref_add(a, b, 1));
        end

        // R2: random operands and carry
        for (int i = 0; i < 1500; i++) begin
            a = 16'($urandom);
            b = 16'($urandom);
            c = 1'($urandom);
            load_pair(a, b, c);
            chk("R2 random sum", ref_add(a, b, c));
        end

        // R10: subtraction through the complemented operand
        for (int i = 0; i < 300; i++) begin
            a = 16'($urandom);
            b = (i % 3 == 0) ? a : 16'($urandom);
            load_pair(a, ~b, 1);
            chk("R10 subtract", {(a >= b) ? 1'b1 : 1'b0, 16'(a - b)});
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule